// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block copies a fixed run of 160 bytes from the system address space into the 160-byte object attribute RAM. The CPU starts a copy by presenting a 16-bit source base address together with a one-cycle start strobe. The engine reads the source through a read master port and writes each byte into the attribute RAM through a simple write port. The destination index starts at zero, and the source address and the destination index both advance by one per byte.

While a copy runs the engine owns the system bus. It gates the CPU so that only the high RAM window 0xFF80..0xFFFE stays reachable. Blocked reads return 0xFF and blocked writes never reach the bus. The engine is a three-state machine:
- `ST_IDLE`: no copy is running.
- `ST_LEAD`: the fixed start latency before the first byte.
- `ST_MOVE`: one byte every four cycles.

The transitions are:
- *accept*: from any state to `ST_LEAD`, on a start with a legal base.
- *first byte*: `ST_LEAD` to `ST_MOVE`, when the latency count reaches zero.
- *next byte*: `ST_MOVE` back to `ST_MOVE`, after each byte that is not the last.
- *done*: `ST_MOVE` to `ST_IDLE`, after the last byte.

Top module: `oam_copy_engine`

## Requirements
- R1: A start whose base is above 0xF100 is ignored in every state: no copy begins, and a running copy continues unchanged. A base of exactly 0xF100 is accepted.
- R2: An accepted copy writes exactly 160 bytes. Byte i goes to attribute index i (0..159) and is read from source address base+i.
- R3: If the start is sampled at clock edge k, byte i is committed at edge k+8+4*i, so the last byte commits at edge k+644.
- R4: While busy, CPU accesses to addresses below 0xFF80 or to 0xFFFF are blocked. A read returns 0xFF on `cpu_rdata_o` and is not forwarded, and a write is not forwarded.
- R5: While busy, CPU reads and writes to 0xFF80..0xFFFE are forwarded to the bus, and the bus read data is returned.
- R6: After the last byte is committed, every CPU access is forwarded normally again.
- R7: A legal start during a running copy restarts it from the new base, with the destination reset to 0 and the 8-cycle latency applied again. Writes pending for the old copy are abandoned.
- R8: `busy_o` is low out of reset. It is high from the cycle after an accepted start until the cycle after the last byte commits.
- R9: Each byte is read on the source port (`src_rd_o` high, `src_addr_o` = base+i) in the same cycle that `oam_we_o` is high. The byte on `src_data_i` is what gets written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| start_base_i | input | 16 | Source base address sampled with the strobe |
| src_rd_o | output | 1 | Source read enable |
| src_addr_o | output | 16 | Source read address |
| src_data_i | input | 8 | Source read data, same cycle |
| oam_we_o | output | 1 | Attribute RAM write enable |
| oam_addr_o | output | 8 | Attribute RAM index |
| oam_wdata_o | output | 8 | Attribute RAM write data |
| busy_o | output | 1 | Copy in progress |
| cpu_addr_i | input | 16 | CPU access address |
| cpu_rd_i | input | 1 | CPU read request |
| cpu_wr_i | input | 1 | CPU write request |
| cpu_rdata_o | output | 8 | Read data returned to the CPU |
| cpu_bus_rd_o | output | 1 | CPU read forwarded to the bus |
| cpu_bus_wr_o | output | 1 | CPU write forwarded to the bus |
| cpu_bus_rdata_i | input | 8 | Bus read data for the CPU |

## Verification
The bench goes after the 0xF100/0xF101 base boundary. A design that compared with the wrong sign would either start a copy that must be refused, or refuse the highest legal base. It also probes the edges of the high RAM window (0xFF7F, 0xFF80, 0xFFFE, 0xFFFF) mid-copy, where an off-by-one in the gate would leak a write to the bus or lock the CPU out of its stack. A restart issued between two byte slots, and an illegal start mid-copy, show whether a design fails to reset the destination, keeps the old cadence, or lets an ignored request disturb the running copy. The exact edge where `busy_o` falls is also checked, since ending one slot early or late shortens or stretches the CPU lockout.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_MOVE = 2'd2
    } dma_state_e;

    localparam logic [7:0] BLOCKED_READ_VALUE = 8'hFF;

endpackage

// File: rtl/oam_dma_seq.sv
module oam_dma_seq
    import oam_dma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN      = 160,
    parameter int LEAD_CYC = 8,
    parameter int GAP_CYC  = 4,
    parameter logic [ADDR_W-1:0] MAX_BASE = 16'hF100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              fire_o,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [$clog2(LEN)-1:0] dst_idx_o,
    output logic              busy_o
);

    localparam int IDX_W  = $clog2(LEN);
    localparam int MAXC   = (LEAD_CYC > GAP_CYC) ? LEAD_CYC : GAP_CYC;
    localparam int CNT_W  = $clog2(MAXC) + 1;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(LEN - 1);
    localparam logic [CNT_W-1:0] LEAD_LOAD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(GAP_CYC - 1);

    dma_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              accept;
    logic              slot;
    logic              last;

    assign accept = start_i && (base_i <= MAX_BASE);
    assign slot   = (state_q != ST_IDLE) && (cnt_q == '0);
    assign last   = (idx_q == LAST_IDX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        base_d  = base_q;
        if (accept) begin
            state_d = ST_LEAD;
            cnt_d   = LEAD_LOAD;
            idx_d   = '0;
            base_d  = base_i;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_LEAD: begin
                    if (cnt_q == '0) begin
                        state_d = ST_MOVE;
                        cnt_d   = GAP_LOAD;
                        idx_d   = idx_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_MOVE: begin
                    if (cnt_q == '0) begin
                        if (last) begin
                            state_d = ST_IDLE;
                            idx_d   = '0;
                        end else begin
                            cnt_d = GAP_LOAD;
                            idx_d = idx_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            base_q  <= base_d;
        end
    end

    // outputs
    always_comb begin
        fire_o     = slot;
        busy_o     = (state_q != ST_IDLE);
        dst_idx_o  = idx_q;
        src_addr_o = base_q + ADDR_W'(idx_q);
    end

    assert_ignore_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && base_i > MAX_BASE) |=> !busy_o);

    assert_first_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && fire_o) |-> (dst_idx_o == '0));

    assert_slot_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    assert_no_instant_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !fire_o);

    assert_release_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(fire_o));

    assert_write_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> busy_o);

endmodule

// File: rtl/oam_dma_gate.sv
module oam_dma_gate
    import oam_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] HRAM_LO = 16'hFF80,
    parameter logic [ADDR_W-1:0] IE_ADDR = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [DATA_W-1:0] cpu_rdata_o
);

    logic in_window;
    logic blocked;

    assign in_window = (cpu_addr_i >= HRAM_LO) && (cpu_addr_i != IE_ADDR);
    assign blocked   = busy_i && !in_window;

    always_comb begin
        bus_rd_o    = cpu_rd_i && !blocked;
        bus_wr_o    = cpu_wr_i && !blocked;
        cpu_rdata_o = blocked ? DATA_W'(BLOCKED_READ_VALUE) : bus_rdata_i;
    end

    assert_block_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cpu_addr_i < HRAM_LO) |-> (!bus_wr_o && !bus_rd_o && cpu_rdata_o == DATA_W'(8'hFF)));

    assert_block_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cpu_addr_i == IE_ADDR) |-> (!bus_wr_o && !bus_rd_o));

    assert_hram_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cpu_addr_i >= HRAM_LO && cpu_addr_i != IE_ADDR)
            |-> (bus_rd_o == cpu_rd_i && bus_wr_o == cpu_wr_i && cpu_rdata_o == bus_rdata_i));

    assert_idle_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (bus_rd_o == cpu_rd_i && bus_wr_o == cpu_wr_i));

endmodule

// File: rtl/oam_copy_engine.sv
module oam_copy_engine
    import oam_dma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LEN      = 160,
    parameter int LEAD_CYC = 8,
    parameter int GAP_CYC  = 4,
    parameter logic [ADDR_W-1:0] MAX_BASE = 16'hF100,
    parameter logic [ADDR_W-1:0] HRAM_LO  = 16'hFF80,
    parameter logic [ADDR_W-1:0] IE_ADDR  = 16'hFFFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ADDR_W-1:0]      start_base_i,
    output logic                   src_rd_o,
    output logic [ADDR_W-1:0]      src_addr_o,
    input  logic [DATA_W-1:0]      src_data_i,
    output logic                   oam_we_o,
    output logic [$clog2(LEN)-1:0] oam_addr_o,
    output logic [DATA_W-1:0]      oam_wdata_o,
    output logic                   busy_o,
    input  logic [ADDR_W-1:0]      cpu_addr_i,
    input  logic                   cpu_rd_i,
    input  logic                   cpu_wr_i,
    output logic [DATA_W-1:0]      cpu_rdata_o,
    output logic                   cpu_bus_rd_o,
    output logic                   cpu_bus_wr_o,
    input  logic [DATA_W-1:0]      cpu_bus_rdata_i
);

    logic fire;
    logic busy;

    oam_dma_seq #(
        .ADDR_W   (ADDR_W),
        .LEN      (LEN),
        .LEAD_CYC (LEAD_CYC),
        .GAP_CYC  (GAP_CYC),
        .MAX_BASE (MAX_BASE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .base_i     (start_base_i),
        .fire_o     (fire),
        .src_addr_o (src_addr_o),
        .dst_idx_o  (oam_addr_o),
        .busy_o     (busy)
    );

    oam_dma_gate #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HRAM_LO (HRAM_LO),
        .IE_ADDR (IE_ADDR)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_rd_i    (cpu_rd_i),
        .cpu_wr_i    (cpu_wr_i),
        .bus_rdata_i (cpu_bus_rdata_i),
        .bus_rd_o    (cpu_bus_rd_o),
        .bus_wr_o    (cpu_bus_wr_o),
        .cpu_rdata_o (cpu_rdata_o)
    );

    always_comb begin
        src_rd_o    = fire;
        oam_we_o    = fire;
        oam_wdata_o = src_data_i;
        busy_o      = busy;
    end

    assert_read_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oam_we_o |-> (src_rd_o && oam_wdata_o == src_data_i));

endmodule

// File: tb/oam_copy_engine_bench.sv
module oam_copy_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [15:0] start_base_i;
    logic        src_rd_o;
    logic [15:0] src_addr_o;
    logic [7:0]  src_data_i;
    logic        oam_we_o;
    logic [7:0]  oam_addr_o;
    logic [7:0]  oam_wdata_o;
    logic        busy_o;
    logic [15:0] cpu_addr_i;
    logic        cpu_rd_i;
    logic        cpu_wr_i;
    logic [7:0]  cpu_rdata_o;
    logic        cpu_bus_rd_o;
    logic        cpu_bus_wr_o;
    logic [7:0]  cpu_bus_rdata_i;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int          edge_n;
        logic [15:0] src;
        logic [7:0]  dst;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] src_mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign src_data_i      = src_rd_o ? src_mem(src_addr_o) : 8'h00;
    assign cpu_bus_rdata_i = 8'h3C;

    oam_copy_engine u_oam_copy_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .start_base_i    (start_base_i),
        .src_rd_o        (src_rd_o),
        .src_addr_o      (src_addr_o),
        .src_data_i      (src_data_i),
        .oam_we_o        (oam_we_o),
        .oam_addr_o      (oam_addr_o),
        .oam_wdata_o     (oam_wdata_o),
        .busy_o          (busy_o),
        .cpu_addr_i      (cpu_addr_i),
        .cpu_rd_i        (cpu_rd_i),
        .cpu_wr_i        (cpu_wr_i),
        .cpu_rdata_o     (cpu_rdata_o),
        .cpu_bus_rd_o    (cpu_bus_rd_o),
        .cpu_bus_wr_o    (cpu_bus_wr_o),
        .cpu_bus_rdata_i (cpu_bus_rdata_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every attribute write
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && oam_we_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected write, index", int'(oam_addr_o), -1);
            end else begin
                e = exp_q.pop_front();
                check(oam_addr_o == e.dst, "R2 destination index", int'(oam_addr_o), int'(e.dst));
                check(src_rd_o && src_addr_o == e.src, "R9 source address", int'(src_addr_o), int'(e.src));
                check(oam_wdata_o == src_mem(e.src), "R9 copied byte", int'(oam_wdata_o), int'(src_mem(e.src)));
                check(cyc + 1 == e.edge_n, "R3 commit edge", cyc + 1, e.edge_n);
            end
        end
    end

    // driver: called at a negedge, the strobe is sampled at the next edge
    task automatic pulse_start(input logic [15:0] base, output int k);
        start_i      = 1'b1;
        start_base_i = base;
        k            = cyc + 1;
        if (base <= 16'hF100) begin
            exp_q.delete();
            for (int i = 0; i < 160; i++) begin
                exp_t e;
                e.edge_n = k + 8 + 4 * i;
                e.src    = base + 16'(i);
                e.dst    = 8'(i);
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic cpu_probe(input logic [15:0] a, input bit rd, input bit wr,
                             input logic [7:0] exp_rdata, input bit exp_brd,
                             input bit exp_bwr, input string tag);
        cpu_addr_i = a;
        cpu_rd_i   = rd;
        cpu_wr_i   = wr;
        #1;
        if (rd) check(cpu_rdata_o == exp_rdata, {tag, " read data"}, int'(cpu_rdata_o), int'(exp_rdata));
        check(cpu_bus_rd_o == exp_brd, {tag, " bus read"}, int'(cpu_bus_rd_o), int'(exp_brd));
        check(cpu_bus_wr_o == exp_bwr, {tag, " bus write"}, int'(cpu_bus_wr_o), int'(exp_bwr));
        cpu_rd_i = 1'b0;
        cpu_wr_i = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wait_idle(input int k, input string tag);
        while (busy_o) @(negedge clk);
        check(cyc == k + 644, {tag, " busy falls after last byte"}, cyc, k + 644);
    endtask

    task automatic run();
        int k, k2, dummy;
        rst_n = 1'b0; start_i = 1'b0; start_base_i = '0;
        cpu_addr_i = '0; cpu_rd_i = 1'b0; cpu_wr_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R8 reset busy", int'(busy_o), 0);
        check(oam_we_o == 1'b0, "R8 reset write enable", int'(oam_we_o), 0);

        // R1: base just above the limit is refused
        pulse_start(16'hF101, dummy);
        check(busy_o == 1'b0, "R1 base 0xF101 ignored", int'(busy_o), 0);
        repeat (20) @(negedge clk);
        check(busy_o == 1'b0, "R1 still idle", int'(busy_o), 0);

        // R1 boundary: 0xF100 accepted, full copy with gating probes
        pulse_start(16'hF100, k);
        check(busy_o == 1'b1, "R8 busy after accepted start", int'(busy_o), 1);
        wait_until(k + 20);
        cpu_probe(16'hC000, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, "R4 work RAM");
        cpu_probe(16'h8000, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R4 write 0x8000");
        cpu_probe(16'hFF7F, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, "R4 0xFF7F");
        cpu_probe(16'hFFFF, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, "R4 0xFFFF read");
        cpu_probe(16'hFFFF, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R4 0xFFFF write");
        cpu_probe(16'hFF80, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, "R5 0xFF80 read");
        cpu_probe(16'hFFFE, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, "R5 0xFFFE write");
        cpu_probe(16'hFF90, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, "R5 0xFF90 read");
        wait_idle(k, "R8");
        check(exp_q.size() == 0, "R2 all 160 bytes written", exp_q.size(), 0);
        @(negedge clk);
        cpu_probe(16'hC000, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, "R6 read restored");
        cpu_probe(16'h8000, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, "R6 write restored");

        // R7 restart, with an illegal start in between (R1 while busy)
        repeat (3) @(negedge clk);
        pulse_start(16'hC000, k);
        wait_until(k + 50);
        pulse_start(16'hF200, dummy);
        check(busy_o == 1'b1, "R1 illegal start while busy leaves copy running", int'(busy_o), 1);
        wait_until(k + 69);
        pulse_start(16'hD010, k2);
        cpu_probe(16'hD000, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, "R7 still gated after restart");
        wait_idle(k2, "R7");
        check(exp_q.size() == 0, "R7 restarted copy complete", exp_q.size(), 0);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule